// File: doc/BRIEF.md
# Operand Address Generator

This block turns an instruction's operand field and a 3-bit mode code into an operand value and the effective address it came from. It supports eight modes. In three of them the operand is available without touching memory: the literal field, a general register, or the top-of-stack register. Four modes fetch the operand with one memory read from an address built from the field or from registers. The memory-indirect mode makes two chained reads. The first read returns a pointer, and the second read fetches the operand at that pointer.

A pipeline stage raises `start_i` for one cycle while the block is idle. In that same cycle it presents the mode, the field, the two register-file read values and the top-of-stack value. The block samples all of these on the accepting edge and ignores them afterwards. It drives one synchronous memory read port. The memory samples a request on the clock edge that ends a cycle in which `mem_req_o` is high, and returns the data in the following cycle. When the work is complete, `done_o` pulses for one cycle with the operand and the final effective address.

Top module: `opnd_addr_gen`

## Requirements
- R1: Mode code 0 (literal): the operand is `field_i`, no memory request is made, and the effective address is 0.
- R2: Mode code 1 (absolute): one read is made at address `field_i`. The operand is the returned word and the effective address is `field_i`.
- R3: Mode code 2 (memory-indirect): the first read is at `field_i` and returns a pointer P. A second read is made at P. The operand is the word at P and the effective address is P.
- R4: Mode code 3 (register): the operand is the register selected by `field_i[2:0]`, no memory request is made, and the effective address is 0.
- R5: Mode code 4 (register-pointer): the register selected by `field_i[2:0]` is the effective address, and the operand is the word read there.
- R6: Mode code 5 (base plus offset): the effective address is the register selected by `field_i[2:0]` plus `field_i[15:8]` sign-extended to 16 bits, modulo 2^16. The operand is read at that address.
- R7: Mode code 6 (base plus index): the effective address is the register selected by `field_i[2:0]` plus the register selected by `field_i[5:3]`, modulo 2^16. The operand is read at that address.
- R8: Mode code 7 (stack top): the operand is `tos_i`, no memory request is made, and the effective address is 0.
- R9: Latency is counted in cycles after the accepting edge. `done_o` is high in cycle 1 for modes that need no read, in cycle 3 for modes that need one read, and in cycle 5 for mode 2. Each memory request lasts exactly one cycle, and `mem_addr_o` holds its value through the following cycle, in which the data returns.
- R10: A `start_i` seen while `busy_o` is high is ignored. Each accepted start produces exactly one `done_o` pulse, `done_o` is never high while `busy_o` is high, and no request is made while idle.
- R11: After reset, `done_o`, `busy_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Begin operand formation (taken only while idle) |
| mode_i | input | 3 | Addressing mode code |
| field_i | input | 16 | Instruction operand field |
| rf_raddr_a_o | output | 3 | Register select for base / single register (`field_i[2:0]`) |
| rf_rdata_a_i | input | 16 | Register value for select A (combinational read) |
| rf_raddr_b_o | output | 3 | Register select for index (`field_i[5:3]`) |
| rf_rdata_b_i | input | 16 | Register value for select B (combinational read) |
| tos_i | input | 16 | Top-of-stack register value |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 16 | Memory read address |
| mem_rdata_i | input | 16 | Memory read data, valid the cycle after a request |
| done_o | output | 1 | One-cycle completion pulse |
| operand_o | output | 16 | Operand value, valid with `done_o` |
| ea_o | output | 16 | Final effective address, valid with `done_o` |
| busy_o | output | 1 | Block is in a multi-cycle sequence |

## Verification
The bound checker watches the handshake on every cycle. It checks that each request lasts one cycle and that its address stays steady through the data cycle. It checks that the block issues no request and raises no `done_o` while it is idle or busy respectively. It also checks that zero-read modes complete on the next cycle with a zero address, and that one-read modes issue a request on the next cycle. The values themselves can only be shown by the bench's scenarios against a modelled memory and register file: the chained pointer read, the sign-extended negative offset, the wrap of both address sums, and the return to idle after two reads. The same applies to showing that a start held high across a busy sequence yields no second result.

// File: rtl/oag_pkg.sv
// Shared types for the operand address generator.
// Assumes mode codes are fixed by the instruction decoder that feeds the block.
package oag_pkg;

    typedef enum logic [2:0] {
        AM_LIT   = 3'd0,
        AM_ABS   = 3'd1,
        AM_MIND  = 3'd2,
        AM_REG   = 3'd3,
        AM_RPTR  = 3'd4,
        AM_BOFS  = 3'd5,
        AM_BIDX  = 3'd6,
        AM_STK   = 3'd7
    } am_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_REQ  = 2'd1,
        SQ_RESP = 2'd2
    } sq_state_e;

    // Number of memory reads each mode needs before the operand is known.
    function automatic logic [1:0] reads_needed(input am_mode_e m);
        case (m)
            AM_LIT, AM_REG, AM_STK: reads_needed = 2'd0;
            AM_MIND:                reads_needed = 2'd2;
            default:                reads_needed = 2'd1;
        endcase
    endfunction

endpackage

// File: rtl/oag_reg_sel.sv
// Register selector: slices the operand field into the two register numbers.
// Assumes the register file reads combinationally within the start cycle.
module oag_reg_sel #(
    parameter int W      = 16,
    parameter int RIDX_W = 3
) (
    input  logic [W-1:0]      field_i,
    output logic [RIDX_W-1:0] sel_a_o,
    output logic [RIDX_W-1:0] sel_b_o
);
    localparam int B_LSB = RIDX_W;
    localparam int B_MSB = 2 * RIDX_W - 1;

    // Base (or sole) register sits in the low bits, the index register just above.
    always_comb begin
        sel_a_o = field_i[RIDX_W-1:0];
        sel_b_o = field_i[B_MSB:B_LSB];
    end
endmodule

// File: rtl/oag_addr_calc.sv
// Address calculator: forms the first memory address, or the operand
// directly for zero-read modes, and reports how many reads the mode needs.
// Purely combinational; assumes its inputs are only sampled on a start edge.
module oag_addr_calc
    import oag_pkg::*;
#(
    parameter int W      = 16,
    parameter int DISP_W = 8
) (
    input  am_mode_e     mode_i,
    input  logic [W-1:0] field_i,
    input  logic [W-1:0] rf_a_i,
    input  logic [W-1:0] rf_b_i,
    input  logic [W-1:0] tos_i,
    output logic [W-1:0] first_addr_o,
    output logic [W-1:0] direct_val_o,
    output logic [1:0]   n_reads_o
);
    localparam int DISP_LSB = W - DISP_W;
    localparam int EXT_W    = W - DISP_W;

    logic [DISP_W-1:0] disp;
    logic [W-1:0]      disp_sx;

    // Sign-extend the offset carried in the top bits of the field.
    always_comb begin
        disp    = field_i[W-1:DISP_LSB];
        disp_sx = {{EXT_W{disp[DISP_W-1]}}, disp};
    end

    // Per-mode address or immediate operand selection; sums wrap at W bits.
    always_comb begin
        first_addr_o = '0;
        direct_val_o = '0;
        n_reads_o    = reads_needed(mode_i);
        case (mode_i)
            AM_LIT:  direct_val_o = field_i;
            AM_ABS:  first_addr_o = field_i;
            AM_MIND: first_addr_o = field_i;
            AM_REG:  direct_val_o = rf_a_i;
            AM_RPTR: first_addr_o = rf_a_i;
            AM_BOFS: first_addr_o = rf_a_i + disp_sx;
            AM_BIDX: first_addr_o = rf_a_i + rf_b_i;
            AM_STK:  direct_val_o = tos_i;
            default: first_addr_o = '0;
        endcase
    end
endmodule

// File: rtl/oag_seq.sv
// Read sequencer: issues zero, one or two chained memory reads and returns
// the operand and final effective address with a one-cycle done pulse.
// Assumes memory data is valid the cycle after the request cycle.
module oag_seq
    import oag_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start_i,
    input  logic [1:0]   n_reads_i,
    input  logic [W-1:0] first_addr_i,
    input  logic [W-1:0] direct_val_i,
    input  logic [W-1:0] mem_rdata_i,
    output logic         mem_req_o,
    output logic [W-1:0] mem_addr_o,
    output logic         done_o,
    output logic [W-1:0] operand_o,
    output logic [W-1:0] ea_o,
    output logic         busy_o
);
    sq_state_e    state_q;
    logic         chain_q;
    logic         req_q;
    logic [W-1:0] addr_q;
    logic         done_q;
    logic [W-1:0] opnd_q;
    logic [W-1:0] ea_q;

    // State machine and result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            chain_q <= 1'b0;
            req_q   <= 1'b0;
            addr_q  <= '0;
            done_q  <= 1'b0;
            opnd_q  <= '0;
            ea_q    <= '0;
        end else begin
            done_q <= 1'b0;
            req_q  <= 1'b0;
            case (state_q)
                SQ_IDLE: begin
                    if (start_i) begin
                        if (n_reads_i == 2'd0) begin
                            done_q <= 1'b1;
                            opnd_q <= direct_val_i;
                            ea_q   <= '0;
                        end else begin
                            req_q   <= 1'b1;
                            addr_q  <= first_addr_i;
                            chain_q <= (n_reads_i == 2'd2);
                            state_q <= SQ_REQ;
                        end
                    end
                end
                SQ_REQ: begin
                    state_q <= SQ_RESP;
                end
                SQ_RESP: begin
                    if (chain_q) begin
                        chain_q <= 1'b0;
                        req_q   <= 1'b1;
                        addr_q  <= mem_rdata_i;
                        state_q <= SQ_REQ;
                    end else begin
                        done_q  <= 1'b1;
                        opnd_q  <= mem_rdata_i;
                        ea_q    <= addr_q;
                        state_q <= SQ_IDLE;
                    end
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    // Drive outputs straight from registers.
    always_comb begin
        mem_req_o  = req_q;
        mem_addr_o = addr_q;
        done_o     = done_q;
        operand_o  = opnd_q;
        ea_o       = ea_q;
        busy_o     = (state_q != SQ_IDLE);
    end
endmodule

// File: rtl/opnd_addr_gen.sv
// Operand address generator top: register selection, address calculation
// and the read sequencer. Assumes mode, field, register and stack-top inputs
// are valid in the cycle start_i is high while idle.
module opnd_addr_gen
    import oag_pkg::*;
#(
    parameter int W      = 16,
    parameter int RIDX_W = 3,
    parameter int DISP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [2:0]        mode_i,
    input  logic [W-1:0]      field_i,
    output logic [RIDX_W-1:0] rf_raddr_a_o,
    input  logic [W-1:0]      rf_rdata_a_i,
    output logic [RIDX_W-1:0] rf_raddr_b_o,
    input  logic [W-1:0]      rf_rdata_b_i,
    input  logic [W-1:0]      tos_i,
    output logic              mem_req_o,
    output logic [W-1:0]      mem_addr_o,
    input  logic [W-1:0]      mem_rdata_i,
    output logic              done_o,
    output logic [W-1:0]      operand_o,
    output logic [W-1:0]      ea_o,
    output logic              busy_o
);
    am_mode_e     mode;
    logic [W-1:0] first_addr;
    logic [W-1:0] direct_val;
    logic [1:0]   n_reads;

    // Cast the raw mode code to the shared enum.
    always_comb mode = am_mode_e'(mode_i);

    oag_reg_sel #(.W(W), .RIDX_W(RIDX_W)) u_sel (
        .field_i (field_i),
        .sel_a_o (rf_raddr_a_o),
        .sel_b_o (rf_raddr_b_o)
    );

    oag_addr_calc #(.W(W), .DISP_W(DISP_W)) u_calc (
        .mode_i       (mode),
        .field_i      (field_i),
        .rf_a_i       (rf_rdata_a_i),
        .rf_b_i       (rf_rdata_b_i),
        .tos_i        (tos_i),
        .first_addr_o (first_addr),
        .direct_val_o (direct_val),
        .n_reads_o    (n_reads)
    );

    oag_seq #(.W(W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .n_reads_i    (n_reads),
        .first_addr_i (first_addr),
        .direct_val_i (direct_val),
        .mem_rdata_i  (mem_rdata_i),
        .mem_req_o    (mem_req_o),
        .mem_addr_o   (mem_addr_o),
        .done_o       (done_o),
        .operand_o    (operand_o),
        .ea_o         (ea_o),
        .busy_o       (busy_o)
    );
endmodule

// File: rtl/oag_checker.sv
// Protocol checker for the operand address generator, bound to the top.
module oag_checker
    import oag_pkg::*;
#(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic [2:0]   mode_i,
    input logic         done_o,
    input logic         busy_o,
    input logic         mem_req_o,
    input logic [W-1:0] mem_addr_o,
    input logic [W-1:0] ea_o
);
    logic take_zero;
    logic take_read;

    // Classify an accepted start by how many reads its mode needs.
    always_comb begin
        take_zero = start_i && !busy_o && (reads_needed(am_mode_e'(mode_i)) == 2'd0);
        take_read = start_i && !busy_o && (reads_needed(am_mode_e'(mode_i)) != 2'd0);
    end

    p_req_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> !mem_req_o);

    p_addr_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_o |=> $stable(mem_addr_o));

    p_zero_read_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_zero |=> (done_o && !mem_req_o));

    p_read_issued_r9: assert property (@(posedge clk) disable iff (!rst_n)
        take_read |=> (mem_req_o && busy_o && !done_o));

    p_zero_ea_r1: assert property (@(posedge clk) disable iff (!rst_n)
        take_zero |=> (ea_o == '0));

    p_done_not_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

    p_idle_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> !mem_req_o);
endmodule

bind opnd_addr_gen oag_checker #(.W(W)) u_oag_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .mode_i     (mode_i),
    .done_o     (done_o),
    .busy_o     (busy_o),
    .mem_req_o  (mem_req_o),
    .mem_addr_o (mem_addr_o),
    .ea_o       (ea_o)
);

// File: tb/opnd_addr_gen_tb_top.sv
`timescale 1ns/1ps
// Scoreboard bench: the driver pushes expected results, the monitor compares them.
module opnd_addr_gen_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  mode = 3'd0;
    logic [15:0] field = 16'h0;
    logic [2:0]  ra, rb;
    logic [15:0] rda, rdb;
    logic [15:0] tos = 16'h0;
    logic        mreq;
    logic [15:0] maddr;
    logic [15:0] mrdata = 16'h0;
    logic        done, busy;
    logic [15:0] opnd, ea;

    logic [15:0] rf [8];
    int cyc = 0;
    int errors = 0;
    int checks = 0;
    int pushed = 0;
    int dones = 0;
    int reads_seen = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [15:0] op;
        logic [15:0] ea;
        int          lat;
        int          reads;
        int          start_cyc;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // Register file and memory models.
    assign rda = rf[ra];
    assign rdb = rf[rb];

    function automatic logic [15:0] memf(input logic [15:0] a);
        return (a ^ 16'h5A3C) + 16'h0101;
    endfunction

    always @(posedge clk) if (mreq) mrdata <= memf(maddr);

    opnd_addr_gen dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode), .field_i(field),
        .rf_raddr_a_o(ra), .rf_rdata_a_i(rda), .rf_raddr_b_o(rb), .rf_rdata_b_i(rdb),
        .tos_i(tos), .mem_req_o(mreq), .mem_addr_o(maddr), .mem_rdata_i(mrdata),
        .done_o(done), .operand_o(opnd), .ea_o(ea), .busy_o(busy)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Expected result from the requirements.
    function automatic exp_t model(input logic [2:0] m, input logic [15:0] f, input string tag);
        exp_t e;
        logic [15:0] a;
        e.tag = tag;
        e.start_cyc = 0;
        case (m)
            3'd0: begin e.op = f; e.ea = 16'h0; e.reads = 0; end
            3'd1: begin e.ea = f; e.op = memf(f); e.reads = 1; end
            3'd2: begin e.ea = memf(f); e.op = memf(e.ea); e.reads = 2; end
            3'd3: begin e.op = rf[f[2:0]]; e.ea = 16'h0; e.reads = 0; end
            3'd4: begin e.ea = rf[f[2:0]]; e.op = memf(e.ea); e.reads = 1; end
            3'd5: begin a = rf[f[2:0]] + {{8{f[15]}}, f[15:8]}; e.ea = a; e.op = memf(a); e.reads = 1; end
            3'd6: begin a = rf[f[2:0]] + rf[f[5:3]]; e.ea = a; e.op = memf(a); e.reads = 1; end
            default: begin e.op = tos; e.ea = 16'h0; e.reads = 0; end
        endcase
        e.lat = (e.reads == 0) ? 1 : (e.reads == 1 ? 3 : 5);
        return e;
    endfunction

    // Driver: start one operation; hold_cycles keeps start high while busy (R10).
    task automatic run_op(input logic [2:0] m, input logic [15:0] f, input string tag,
                          input int hold_cycles);
        exp_t e;
        @(negedge clk);
        mode = m;
        field = f;
        e = model(m, f, tag);
        e.start_cyc = cyc;
        q.push_back(e);
        pushed++;
        start = 1'b1;
        for (int i = 0; i < hold_cycles; i++) begin
            @(negedge clk);
            mode = 3'd0;
            field = 16'hDEAD;
        end
        @(negedge clk);
        start = 1'b0;
        mode = 3'd6;
        field = 16'hFFFF;
        while (busy || q.size() != 0) @(negedge clk);
    endtask

    // Monitor: count requests and compare each completion with the queue head.
    always @(negedge clk) begin
        if (rst_n && mreq) reads_seen++;
        if (rst_n && done) begin
            dones++;
            if (q.size() == 0) begin
                chk(1'b0, "R10", "done with no pending start", 32'd1, 32'd0);
            end else begin
                exp_t e;
                e = q.pop_front();
                chk(opnd == e.op, e.tag, "operand", opnd, e.op);
                chk(ea == e.ea, e.tag, "effective address", ea, e.ea);
                chk(cyc - e.start_cyc == e.lat, "R9", "latency", cyc - e.start_cyc, e.lat);
                chk(reads_seen == e.reads, "R9", "memory reads", reads_seen, e.reads);
            end
            reads_seen = 0;
        end
    end

    initial begin
        for (int i = 0; i < 8; i++) rf[i] = 16'h1111 * i[15:0] + 16'h0200;
        tos = 16'h7E57;
        repeat (3) @(negedge clk);
        // R11: reset state
        chk(!done && !busy && !mreq, "R11", "outputs in reset", {done, busy, mreq}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !busy && !mreq, "R11", "outputs after reset", {done, busy, mreq}, 0);

        run_op(3'd0, 16'hBEEF, "R1", 0);
        run_op(3'd0, 16'h0000, "R1", 0);
        run_op(3'd1, 16'h0040, "R2", 0);
        run_op(3'd1, 16'hFFFF, "R2", 0);
        run_op(3'd2, 16'h0123, "R3", 0);
        run_op(3'd2, 16'h8000, "R3", 0);
        run_op(3'd3, 16'h0003, "R4", 0);
        run_op(3'd3, 16'hFF07, "R4", 0);
        run_op(3'd4, 16'h0002, "R5", 0);
        rf[5] = 16'h0005;
        run_op(3'd5, 16'hF005, "R6", 0);   // negative offset wraps to FFF5
        run_op(3'd5, 16'h1001, "R6", 0);
        rf[6] = 16'hFFF0;
        rf[2] = 16'h0020;
        run_op(3'd6, 16'h0016, "R7", 0);   // FFF0 + 0020 wraps to 0010
        run_op(3'd7, 16'h0000, "R8", 0);
        tos = 16'h8001;
        run_op(3'd7, 16'h1234, "R8", 0);
        // R10: start held high through a whole one-read and two-read sequence
        run_op(3'd1, 16'h0777, "R10", 2);
        run_op(3'd2, 16'h0456, "R10", 4);
        repeat (4) @(negedge clk);
        chk(dones == pushed, "R10", "completions vs accepted starts", dones, pushed);
        chk(!busy && !mreq, "R10", "idle after sequences", {busy, mreq}, 0);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check.
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", dones, pushed);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule